// File: doc/BRIEF.md
# SDRAM Read Burst Output Sequencer

This block is the device-side read path of a synchronous DRAM model. It takes registered commands (read, burst stop, no-op), a start column, the clock-enable pin and the mode settings. From these it produces a stream of read data elements, each tagged with its column index and a data-valid strobe. The first element of a burst arrives a fixed number of clocks after the read command, set by the CAS latency. Later elements follow one per internal clock, in sequential or interleaved order, for a burst of 1, 2, 4 or 8 elements or for a whole page.

A burst can be cut short by a stop command. The stop takes effect with the same latency as the read data, and it has no effect if the read asked for auto precharge. When clock enable is sampled low, the internal clock is suppressed one edge later. While it is suppressed, the burst counter, the latency pipeline and the output hold their values, so the current element stays on the outputs. The storage array is modelled as a synchronous lookup that returns a word derived from the column. That lookup register is the final stage of the latency pipeline.

Top module: `sdr_read_seq`

## Requirements
- R1: After reset `dout_valid` is low and stays low until a read produces data.
- R2: A read registered at internal edge T puts its first element on the outputs after edge T+CL-1, so it is sampled at edge T+CL. `cas_lat` holds CL as the value 2 or 3 and is only changed while no burst is in flight.
- R3: `burst_code` 0, 1, 2 and 3 select 1, 2, 4 and 8 elements, 7 selects a full page, and 4 to 6 behave as length 1. A fixed burst drives exactly that many elements on consecutive internal clocks. `dout_valid` drops on the cycle after the last element.
- R4: In sequential order (`interleave` = 0) with burst length L, element i has the upper column bits of the start column and low log2(L) bits equal to (start + i) mod L.
- R5: In interleaved order (`interleave` = 1), element i has low log2(L) bits equal to (start XOR i) and the upper bits of the start column. The `interleave` input has no effect on a full-page burst.
- R6: A full-page burst gives columns (start + i) mod PAGE_COLS without end, until a stop or a new read.
- R7: With auto precharge clear, a stop registered at internal edge Tb makes the element valid at edge Tb+CL-1 the last one. A stop k internal edges after the read therefore leaves min(k, L) elements.
- R8: A stop command is ignored when the burst in progress was read with `auto_pre` = 1.
- R9: A read registered during a burst restarts issue at the new column on the next internal edge. Elements already in the latency pipeline still emerge in order.
- R10: `cke` low sampled at edge T suppresses the internal clock at edge T+1. During a suppressed edge, `dout_valid`, `dout_col` and `dout_data` keep their values. Advance resumes at the edge after `cke` is sampled high.
- R11: A command presented at a suppressed edge has no effect.
- R12: On every valid element, `dout_data` equals the column zero-extended to DATA_W bits XOR DATA_PATTERN.
- R13: `cmd` encodes 0 and 3 as no-op, 1 as read and 2 as stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command code (R13) |
| start_col | input | COL_W | Start column, taken with a read |
| cke | input | 1 | Clock enable, registered with one edge of latency |
| cas_lat | input | CL_W | CAS latency, 2 or 3 |
| burst_code | input | 3 | Burst length code, taken with a read |
| interleave | input | 1 | Interleaved order select, taken with a read |
| auto_pre | input | 1 | Auto-precharge flag, taken with a read |
| dout_valid | output | 1 | Element on the outputs is valid |
| dout_col | output | COL_W | Column index of the current element |
| dout_data | output | DATA_W | Data word of the current element |

## Verification
Every result is due a number of internal edges after its stimulus, not a number of wall clocks:
- An element appears CL-1 edges after it is issued.
- A stop takes effect at its own edge.
- A low `cke` takes effect one edge after it is sampled.

For each edge the bench counts the internal edges that `cke` allowed since the read. From that count it derives which element the outputs should hold, and it samples at the falling edge after every rising edge. Stops and reads that land on suppressed edges are given no internal time, which is how the ignore cases are predicted.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;
   typedef enum logic [1:0] {
      CMD_NOP  = 2'd0,
      CMD_READ = 2'd1,
      CMD_BST  = 2'd2,
      CMD_IDLE = 2'd3
   } sdr_cmd_e;

   localparam logic [2:0] BL_FULL = 3'b111;
endpackage

// File: rtl/sdr_burst_issue.sv
module sdr_burst_issue
   import sdr_rd_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic [1:0]       cmd,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       burst_code,
   input  logic             interleave,
   input  logic             auto_pre,
   output logic             iss_valid,
   output logic [COL_W-1:0] iss_col
);
   logic             active;
   logic [COL_W-1:0] idx, base, mask;
   logic             il_q, ap_q, full_q;

   function automatic logic [COL_W-1:0] len_mask(input logic [2:0] code);
      logic [COL_W-1:0] m;
      case (code)
         3'd1:    m = COL_W'(1);
         3'd2:    m = COL_W'(3);
         3'd3:    m = COL_W'(7);
         BL_FULL: m = '1;
         default: m = '0;
      endcase
      return m;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         base   <= '0;
         mask   <= '0;
         il_q   <= 1'b0;
         ap_q   <= 1'b0;
         full_q <= 1'b0;
      end else if (ce) begin
         if (cmd == CMD_READ) begin
            active <= 1'b1;
            idx    <= '0;
            base   <= start_col;
            mask   <= len_mask(burst_code);
            il_q   <= interleave && (burst_code != BL_FULL);
            ap_q   <= auto_pre;
            full_q <= (burst_code == BL_FULL);
         end else if (active) begin
            if (cmd == CMD_BST && !ap_q)
               active <= 1'b0;
            else if (!full_q && idx == mask)
               active <= 1'b0;
            else
               idx <= idx + 1'b1;
         end
      end
   end

   always_comb begin
      if (full_q)
         iss_col = base + idx;
      else if (il_q)
         iss_col = (base & ~mask) | ((base ^ idx) & mask);
      else
         iss_col = (base & ~mask) | ((base + idx) & mask);
   end

   assign iss_valid = active;

   // R3: the index never leaves the programmed burst window
   a_r3_idx_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !full_q) |-> ((idx & ~mask) == '0));

   // R8: a stop does not end an auto-precharge burst early
   a_r8_ap_blocks_bst: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && cmd == CMD_BST && active && ap_q && (full_q || idx != mask)) |=> active);

   // R6: a full page keeps running without a stop
   a_r6_full_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && cmd == CMD_NOP && active && full_q) |=> active);
endmodule

// File: rtl/sdr_lat_pipe.sv
module sdr_lat_pipe #(
   parameter int W      = 9,
   parameter int MAX_CL = 3,
   parameter int CL_W   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ce,
   input  logic [CL_W-1:0] cl,
   input  logic            in_valid,
   input  logic [W-1:0]    in_col,
   output logic            out_valid,
   output logic [W-1:0]    out_col
);
   localparam int XTRA = MAX_CL - 2;

   generate
      if (XTRA == 0) begin : g_direct
         assign out_valid = in_valid;
         assign out_col   = in_col;
      end else begin : g_chain
         logic [XTRA-1:0]        v_q;
         logic [XTRA-1:0][W-1:0] c_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q <= '0;
               c_q <= '0;
            end else if (ce) begin
               v_q[0] <= in_valid;
               c_q[0] <= in_col;
               for (int i = 1; i < XTRA; i++) begin
                  v_q[i] <= v_q[i-1];
                  c_q[i] <= c_q[i-1];
               end
            end
         end

         always_comb begin
            out_valid = in_valid;
            out_col   = in_col;
            for (int i = 0; i < XTRA; i++) begin
               if (int'(cl) == i + 3) begin
                  out_valid = v_q[i];
                  out_col   = c_q[i];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sdr_col_lookup.sv
module sdr_col_lookup #(
   parameter int               COL_W   = 9,
   parameter int               DATA_W  = 16,
   parameter logic [DATA_W-1:0] PATTERN = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              in_valid,
   input  logic [COL_W-1:0]  in_col,
   output logic              out_valid,
   output logic [COL_W-1:0]  out_col,
   output logic [DATA_W-1:0] out_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_col   <= '0;
         out_data  <= '0;
      end else if (ce) begin
         out_valid <= in_valid;
         out_col   <= in_col;
         out_data  <= DATA_W'(in_col) ^ PATTERN;
      end
   end
endmodule

// File: rtl/sdr_read_seq.sv
module sdr_read_seq #(
   parameter int                PAGE_COLS    = 512,
   parameter int                DATA_W       = 16,
   parameter int                MAX_CL       = 3,
   parameter logic [DATA_W-1:0] DATA_PATTERN = 16'hA5C3,
   localparam int               COL_W        = $clog2(PAGE_COLS),
   localparam int               CL_W         = $clog2(MAX_CL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd,
   input  logic [COL_W-1:0]  start_col,
   input  logic              cke,
   input  logic [CL_W-1:0]   cas_lat,
   input  logic [2:0]        burst_code,
   input  logic              interleave,
   input  logic              auto_pre,
   output logic              dout_valid,
   output logic [COL_W-1:0]  dout_col,
   output logic [DATA_W-1:0] dout_data
);
   initial begin
      assert (PAGE_COLS == (1 << COL_W) && COL_W >= 3)
         else $error("PAGE_COLS must be a power of two of at least 8");
      assert (MAX_CL >= 2 && DATA_W >= COL_W)
         else $error("MAX_CL below 2 or DATA_W narrower than a column");
   end

   logic             ce_q;
   logic             iss_valid, pipe_valid;
   logic [COL_W-1:0] iss_col, pipe_col;

   always_ff @(posedge clk) begin
      if (!rst_n) ce_q <= 1'b1;
      else        ce_q <= cke;
   end

   sdr_burst_issue #(.COL_W(COL_W)) u_issue (
      .clk(clk), .rst_n(rst_n), .ce(ce_q), .cmd(cmd), .start_col(start_col),
      .burst_code(burst_code), .interleave(interleave), .auto_pre(auto_pre),
      .iss_valid(iss_valid), .iss_col(iss_col)
   );

   sdr_lat_pipe #(.W(COL_W), .MAX_CL(MAX_CL), .CL_W(CL_W)) u_pipe (
      .clk(clk), .rst_n(rst_n), .ce(ce_q), .cl(cas_lat),
      .in_valid(iss_valid), .in_col(iss_col),
      .out_valid(pipe_valid), .out_col(pipe_col)
   );

   sdr_col_lookup #(.COL_W(COL_W), .DATA_W(DATA_W), .PATTERN(DATA_PATTERN)) u_lookup (
      .clk(clk), .rst_n(rst_n), .ce(ce_q),
      .in_valid(pipe_valid), .in_col(pipe_col),
      .out_valid(dout_valid), .out_col(dout_col), .out_data(dout_data)
   );

   // R2: latency setting is always a legal value
   a_r2_cl_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cas_lat) >= 2 && int'(cas_lat) <= MAX_CL));

   // R10: a suppressed internal edge leaves the outputs untouched
   a_r10_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_q |=> ($stable(dout_valid) && $stable(dout_col) && $stable(dout_data)));

   // R12: data word tracks the column it belongs to
   a_r12_data_word: assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid |-> ((dout_data ^ DATA_PATTERN) == DATA_W'(dout_col)));
endmodule

// File: tb/sdr_read_seq_tb.sv
`timescale 1ns/1ps
module sdr_read_seq_tb;
   localparam int          PAGE = 512;
   localparam int          DW   = 16;
   localparam int          CW   = 9;
   localparam logic [15:0] PAT  = 16'hA5C3;
   localparam logic [31:0] ALL  = 32'hFFFF_FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cmd = 2'd0;
   logic [CW-1:0] start_col = '0;
   logic          cke = 1'b1;
   logic [1:0]    cas_lat = 2'd2;
   logic [2:0]    burst_code = 3'd0;
   logic          interleave = 1'b0;
   logic          auto_pre = 1'b0;
   logic          dout_valid;
   logic [CW-1:0] dout_col;
   logic [DW-1:0] dout_data;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   sdr_read_seq #(.PAGE_COLS(PAGE), .DATA_W(DW), .MAX_CL(3), .DATA_PATTERN(PAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .start_col(start_col), .cke(cke),
      .cas_lat(cas_lat), .burst_code(burst_code), .interleave(interleave),
      .auto_pre(auto_pre), .dout_valid(dout_valid), .dout_col(dout_col),
      .dout_data(dout_data)
   );

   initial begin
      #(4 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hung exp done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   function automatic int blen(input int code);
      case (code)
         0: return 1;
         1: return 2;
         2: return 4;
         3: return 8;
         7: return 1000000;
         default: return 1;
      endcase
   endfunction

   function automatic int ecol(input int start, input int code, input int il, input int j);
      int len, low;
      if (code == 7) return (start + j) % PAGE;
      len = blen(code);
      low = il ? ((start % len) ^ j) : (((start % len) + j) % len);
      return start - (start % len) + low;
   endfunction

   // One burst: READ at relative edge 0, optional stop and second read,
   // cke_mask bit k is the cke level sampled at relative edge k.
   task automatic run(input string tag, input int start, input int code, input int il,
                      input int cl, input int ap, input int bst_at, input int rd2_at,
                      input int rd2_col, input logic [31:0] cke_mask);
      int m = 0;
      int t_bst = -1;
      int t_rd2 = -1;
      int len = blen(code);
      cas_lat    = 2'(cl);
      burst_code = 3'(code);
      interleave = il[0];
      auto_pre   = ap[0];
      for (int k = 0; k < 28; k++) begin
         bit en;
         int t, j, ec;
         bit ev;
         en = (k == 0) ? 1'b1 : cke_mask[k-1];
         if (k > 0 && en) m++;
         cmd = 2'd0;
         start_col = CW'(start);
         if (k == 0) cmd = 2'd1;
         if (k == rd2_at) begin
            cmd = 2'd1;
            start_col = CW'(rd2_col);
            if (en) t_rd2 = m;
         end
         if (k == bst_at) begin
            cmd = 2'd2;
            if (en) t_bst = m;
         end
         cke = cke_mask[k];
         @(negedge clk);
         t  = m - (cl - 1);
         ev = 1'b0;
         ec = 0;
         if (t >= 0) begin
            if (t_rd2 >= 0 && t >= t_rd2) begin
               j = t - t_rd2;
               if (j < len) begin
                  ev = 1'b1;
                  ec = ecol(rd2_col, code, il, j);
               end
            end else if (t < len && !(t_bst >= 0 && ap == 0 && t >= t_bst)) begin
               ev = 1'b1;
               ec = ecol(start, code, il, t);
            end
         end
         n_chk++;
         if (dout_valid !== ev || (ev && dout_col !== CW'(ec))) begin
            n_bad++;
            $display("FAIL %s edge %0d: valid/col got %0b/%0d exp %0b/%0d",
                     tag, k, dout_valid, dout_col, ev, ec);
         end
         if (ev) begin
            n_chk++;
            if (dout_data !== (DW'(ec) ^ PAT)) begin
               n_bad++;
               $display("FAIL R12 edge %0d: data got %h exp %h", k, dout_data, DW'(ec) ^ PAT);
            end
         end
      end
      cmd = 2'd0;
      cke = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic sc_reset;
      n_chk++;
      if (dout_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: valid got %0b exp 0", dout_valid);
      end
   endtask

   task automatic sc_sequential;
      run("R2/R4", 13, 2, 0, 2, 0, -1, -1, 0, ALL);
      run("R2/R4", 13, 2, 0, 3, 0, -1, -1, 0, ALL);
   endtask

   task automatic sc_interleaved;
      run("R5", 13, 3, 1, 3, 0, -1, -1, 0, ALL);
      run("R5", 6, 2, 1, 2, 0, -1, -1, 0, ALL);
   endtask

   task automatic sc_lengths;
      run("R3", 77, 0, 0, 3, 0, -1, -1, 0, ALL);
      run("R3", 77, 1, 0, 2, 0, -1, -1, 0, ALL);
      run("R3/R13", 200, 5, 0, 2, 0, -1, -1, 0, ALL);
   endtask

   task automatic sc_full_page;
      run("R6/R5", 509, 7, 1, 2, 0, 6, -1, 0, ALL);
   endtask

   task automatic sc_terminate;
      run("R7", 13, 2, 0, 2, 0, 1, -1, 0, ALL);
      run("R7", 13, 2, 0, 3, 0, 1, -1, 0, ALL);
      run("R7", 13, 2, 0, 2, 0, 3, -1, 0, ALL);
      run("R7", 40, 3, 0, 3, 0, 5, -1, 0, ALL);
   endtask

   task automatic sc_auto_pre;
      run("R8", 13, 2, 0, 2, 1, 1, -1, 0, ALL);
   endtask

   task automatic sc_reread;
      run("R9", 100, 3, 0, 2, 0, -1, 2, 40, ALL);
   endtask

   task automatic sc_suspend;
      run("R10", 20, 2, 0, 2, 0, -1, -1, 0, 32'hFFFF_FFFB);
      run("R10/R11", 20, 3, 0, 3, 0, 3, -1, 0, 32'hFFFF_FFF9);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      sc_reset();
      sc_sequential();
      sc_interleaved();
      sc_lengths();
      sc_full_page();
      sc_terminate();
      sc_auto_pre();
      sc_reread();
      sc_suspend();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule